// File: doc/BRIEF.md
# Sign-Split Dual DAC Driver

This block turns one signed actuator command into two unipolar converter codes. Two opposing actuators each have their own parallel-input DAC. The sign of the command picks which of the two gets the command's magnitude. The other DAC is always loaded with zero, so the two actuators are never energised against each other.

A controller raises a one-cycle update request together with the signed command. The block latches the command and forms its absolute value, clipped to the converter's full scale. It then runs two write cycles over a shared data bus: first the zero to the idle side, then the magnitude to the driving side. Each write has its own chip-select and a common write strobe. A single-cycle completion pulse closes the sequence.

A request that arrives while a sequence is running is held and started once the current sequence has finished. Only the most recent held command is kept.

Top module: `sign_split_dac`

## Requirements
- R1: While reset is held and after it is released with no request, both chip-selects and the write strobe are high, the data bus is zero, and busy and done are low.
- R2: A command greater than zero results in a write of the saturated magnitude to DAC A and a write of zero to DAC B.
- R3: A command less than zero results in a write of the saturated magnitude to DAC B and a write of zero to DAC A.
- R4: A zero command writes zero to both DACs, DAC B first and then DAC A.
- R5: The magnitude written is the absolute value of the two's complement command, limited to 2^DAC_W-1. The most negative input value is included.
- R6: In every sequence the DAC that receives zero is written before the DAC that receives the magnitude.
- R7: In each write, the data appears on the bus one cycle before the strobes fall. The chip-select and the active-low write strobe are then low together for exactly STROBE_CYC cycles with the data stable. The strobes are then released for one cycle while the data is still held.
- R8: The two chip-selects are never low in the same cycle.
- R9: Busy is high from the cycle after an accepted request until the end of the sequence. Done is high for exactly one cycle, after the second write has been released, and only while busy is high.
- R10: A request made while busy, including in the done cycle, is held and run as one further sequence after the current one. If several arrive, only the last command is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_req | input | 1 | One-cycle update request |
| upd_cmd | input | IN_W | Signed command, two's complement, sampled with upd_req |
| dac_data | output | DAC_W | Shared converter data bus |
| dac_a_cs_n | output | 1 | Active-low select of DAC A (positive direction) |
| dac_b_cs_n | output | 1 | Active-low select of DAC B (negative direction) |
| dac_wr_n | output | 1 | Active-low write strobe shared by both DACs |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Two situations are hard to reach from the ports: a request held while a sequence is running, and the case where a held command is overwritten. Both depend on when the request arrives relative to the write sequence. The stimulus places two requests at fixed offsets inside a running sequence, and a third exactly in the cycle where done is observed high. It then counts the writes on the bus until the block has been idle for a while. Saturation and the most negative input are reached by a strided sweep over the whole 16-bit command range, together with the values on either side of full scale.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STRB,
      ST_HOLD,
      ST_DONE
   } ssd_state_e;
endpackage

// File: rtl/ssd_magsat.sv
module ssd_magsat #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 14
) (
   input  logic signed [IN_W-1:0]  cmd,
   output logic [OUT_W-1:0]        mag,
   output logic                    neg
);
   localparam int AW = IN_W + 1;

   logic [AW-1:0] ext;
   logic [AW-1:0] absv;

   always_comb begin
      ext  = {cmd[IN_W-1], cmd};
      absv = cmd[IN_W-1] ? (~ext + AW'(1)) : ext;
      neg  = cmd[IN_W-1];
   end

   generate
      if (IN_W > OUT_W) begin : g_sat
         logic over;
         always_comb begin
            over = |absv[AW-1:OUT_W];
            mag  = over ? {OUT_W{1'b1}} : absv[OUT_W-1:0];
         end
      end else begin : g_wide
         always_comb mag = OUT_W'(absv[IN_W-1:0]);
      end
   endgenerate
endmodule

// File: rtl/ssd_req_hold.sv
module ssd_req_hold #(
   parameter int IN_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req,
   input  logic [IN_W-1:0]        cmd,
   input  logic                   busy,
   output logic                   start,
   output logic [IN_W-1:0]        start_cmd
);
   logic            pend;
   logic [IN_W-1:0] pend_cmd;

   always_comb begin
      start     = !busy && (req || pend);
      start_cmd = req ? cmd : pend_cmd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         pend_cmd <= '0;
      end else if (start) begin
         pend     <= 1'b0;
      end else if (req && busy) begin
         pend     <= 1'b1;
         pend_cmd <= cmd;
      end
   end
endmodule

// File: rtl/ssd_seq.sv
module ssd_seq
   import ssd_pkg::*;
#(
   parameter int IN_W       = 16,
   parameter int DAC_W      = 14,
   parameter int STROBE_CYC = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [IN_W-1:0]     start_cmd,
   input  logic [DAC_W-1:0]    mag,
   input  logic                neg,
   output logic [IN_W-1:0]     cmd_q,
   output logic [DAC_W-1:0]    dac_data,
   output logic                cs_a_n,
   output logic                cs_b_n,
   output logic                wr_n,
   output logic                busy,
   output logic                done
);
   localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

   ssd_state_e      state;
   logic            second;
   logic [CW-1:0]   cnt;
   logic            on_bus;
   logic            strobe;
   logic            tgt_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         second <= 1'b0;
         cnt    <= '0;
         cmd_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               cmd_q  <= start_cmd;
               second <= 1'b0;
               state  <= ST_SETUP;
            end
            ST_SETUP: begin
               cnt   <= '0;
               state <= ST_STRB;
            end
            ST_STRB: begin
               if (cnt == LAST) state <= ST_HOLD;
               else             cnt   <= cnt + CW'(1);
            end
            ST_HOLD: begin
               if (second) state <= ST_DONE;
               else begin
                  second <= 1'b1;
                  state  <= ST_SETUP;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      on_bus   = (state == ST_SETUP) || (state == ST_STRB) || (state == ST_HOLD);
      strobe   = (state == ST_STRB);
      tgt_b    = second ? neg : !neg;
      dac_data = (on_bus && second) ? mag : '0;
      cs_a_n   = !(strobe && !tgt_b);
      cs_b_n   = !(strobe && tgt_b);
      wr_n     = !strobe;
      busy     = (state != ST_IDLE);
      done     = (state == ST_DONE);
   end
endmodule

// File: rtl/sign_split_dac.sv
module sign_split_dac #(
   parameter int IN_W       = 16,
   parameter int DAC_W      = 14,
   parameter int STROBE_CYC = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd_req,
   input  logic signed [IN_W-1:0]  upd_cmd,
   output logic [DAC_W-1:0]        dac_data,
   output logic                    dac_a_cs_n,
   output logic                    dac_b_cs_n,
   output logic                    dac_wr_n,
   output logic                    busy,
   output logic                    done
);
   generate
      if (IN_W < 2) begin : g_bad_in
         $error("sign_split_dac: IN_W must be at least 2");
      end
      if (DAC_W < 1) begin : g_bad_dac
         $error("sign_split_dac: DAC_W must be at least 1");
      end
      if (STROBE_CYC < 1) begin : g_bad_strb
         $error("sign_split_dac: STROBE_CYC must be at least 1");
      end
   endgenerate

   logic              start;
   logic [IN_W-1:0]   start_cmd;
   logic [IN_W-1:0]   cmd_q;
   logic [DAC_W-1:0]  mag;
   logic              neg;

   ssd_req_hold #(.IN_W(IN_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (upd_req),
      .cmd       (upd_cmd),
      .busy      (busy),
      .start     (start),
      .start_cmd (start_cmd)
   );

   ssd_magsat #(.IN_W(IN_W), .OUT_W(DAC_W)) u_mag (
      .cmd (cmd_q),
      .mag (mag),
      .neg (neg)
   );

   ssd_seq #(.IN_W(IN_W), .DAC_W(DAC_W), .STROBE_CYC(STROBE_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_cmd (start_cmd),
      .mag       (mag),
      .neg       (neg),
      .cmd_q     (cmd_q),
      .dac_data  (dac_data),
      .cs_a_n    (dac_a_cs_n),
      .cs_b_n    (dac_b_cs_n),
      .wr_n      (dac_wr_n),
      .busy      (busy),
      .done      (done)
   );
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
   parameter int DAC_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DAC_W-1:0] dac_data,
   input logic             dac_a_cs_n,
   input logic             dac_b_cs_n,
   input logic             dac_wr_n,
   input logic             busy,
   input logic             done
);
   // R8
   excl_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dac_a_cs_n && !dac_b_cs_n));

   // R7
   setup_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_a_cs_n) |-> $stable(dac_data));

   // R7
   setup_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_b_cs_n) |-> $stable(dac_data));

   // R7
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_wr_n) |-> $stable(dac_data));

   // R7
   wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_wr_n == (dac_a_cs_n && dac_b_cs_n));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dac_a_cs_n && dac_b_cs_n && dac_wr_n));
endmodule

bind sign_split_dac ssd_checker #(.DAC_W(DAC_W)) u_ssd_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dac_data   (dac_data),
   .dac_a_cs_n (dac_a_cs_n),
   .dac_b_cs_n (dac_b_cs_n),
   .dac_wr_n   (dac_wr_n),
   .busy       (busy),
   .done       (done)
);

// File: tb/sign_split_dac_bench.sv
module sign_split_dac_bench;
   localparam int CLK_PERIOD = 10;
   localparam int STRB_CYC   = 2;
   localparam int FULL       = 16383;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               upd_req = 1'b0;
   logic signed [15:0] upd_cmd = '0;
   logic [13:0]        dac_data;
   logic               dac_a_cs_n, dac_b_cs_n, dac_wr_n, busy, done;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   // write log: target 0 = DAC A, 1 = DAC B
   int wr_tgt [0:7];
   int wr_val [0:7];
   int n_wr = 0;
   int done_cnt = 0;
   logic prev_a = 1'b1, prev_b = 1'b1;
   logic [13:0] prev_data = '0;
   int low_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sign_split_dac #(.IN_W(16), .DAC_W(14), .STROBE_CYC(STRB_CYC)) u_sign_split_dac (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_req    (upd_req),
      .upd_cmd    (upd_cmd),
      .dac_data   (dac_data),
      .dac_a_cs_n (dac_a_cs_n),
      .dac_b_cs_n (dac_b_cs_n),
      .dac_wr_n   (dac_wr_n),
      .busy       (busy),
      .done       (done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bus monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (!dac_a_cs_n || !dac_b_cs_n) low_cnt++;
         if ((prev_a && !dac_a_cs_n) || (prev_b && !dac_b_cs_n))
            check(dac_data == prev_data, "R7 setup", int'(dac_data), int'(prev_data));
         if ((!prev_a && dac_a_cs_n) || (!prev_b && dac_b_cs_n)) begin
            check(low_cnt == STRB_CYC, "R7 strobe width", low_cnt, STRB_CYC);
            check(dac_data == prev_data, "R7 hold", int'(dac_data), int'(prev_data));
            if (n_wr < 8) begin
               wr_tgt[n_wr] = prev_a ? 1 : 0;
               wr_val[n_wr] = int'(prev_data);
            end
            n_wr++;
            low_cnt = 0;
         end
         if (done) done_cnt++;
      end
      prev_a    = dac_a_cs_n;
      prev_b    = dac_b_cs_n;
      prev_data = dac_data;
   end

   function automatic int exp_mag(input int v);
      int a;
      a = (v < 0) ? -v : v;
      return (a > FULL) ? FULL : a;
   endfunction

   task automatic clear_log();
      @(posedge clk);
      n_wr = 0;
      done_cnt = 0;
   endtask

   task automatic pulse_req(input int v);
      @(negedge clk);
      upd_req = 1'b1;
      upd_cmd = 16'(v);
      @(negedge clk);
      upd_req = 1'b0;
   endtask

   task automatic wait_done(input int want);
      for (int i = 0; i < 80 && done_cnt < want; i++) @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   // check one recorded sequence starting at log index base
   task automatic check_pair(input int base, input int v);
      int first_t, second_t;
      first_t  = (v < 0) ? 0 : 1;
      second_t = 1 - first_t;
      if (v > 0) begin
         // R2: zero to B, magnitude to A
         check(wr_tgt[base+1] == 0, "R2 target", wr_tgt[base+1], 0);
      end else if (v < 0) begin
         // R3: zero to A, magnitude to B
         check(wr_tgt[base+1] == 1, "R3 target", wr_tgt[base+1], 1);
      end else begin
         // R4: B then A, both zero
         check(wr_tgt[base] == 1 && wr_val[base+1] == 0, "R4 zero order",
               wr_tgt[base], 1);
      end
      // R6: inactive side gets zero first
      check(wr_tgt[base] == first_t && wr_val[base] == 0, "R6 first write",
            wr_val[base], 0);
      check(wr_tgt[base+1] == second_t, "R6 second target", wr_tgt[base+1], second_t);
      // R5: saturated magnitude
      check(wr_val[base+1] == exp_mag(v), "R5 magnitude", wr_val[base+1], exp_mag(v));
   endtask

   task automatic run_cmd(input int v);
      clear_log();
      pulse_req(v);
      // R9: busy in the cycle after the request edge
      check(busy == 1'b1, "R9 busy", int'(busy), 1);
      wait_done(1);
      check(n_wr == 2, "R2 write count", n_wr, 2);
      check(done_cnt == 1, "R9 single done", done_cnt, 1);
      check(busy == 1'b0, "R9 idle after", int'(busy), 0);
      if (n_wr == 2) check_pair(0, v);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: under reset
      check(dac_a_cs_n && dac_b_cs_n && dac_wr_n, "R1 strobes in reset", 0, 1);
      check(dac_data == '0 && !busy && !done, "R1 bus in reset", int'(dac_data), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(dac_a_cs_n && dac_b_cs_n && dac_wr_n && !busy && !done && dac_data == '0,
            "R1 idle after reset", int'(busy), 0);

      // corners: R2 R3 R4 R5
      run_cmd(0);
      run_cmd(1);
      run_cmd(-1);
      run_cmd(FULL);
      run_cmd(FULL + 1);
      run_cmd(-FULL);
      run_cmd(-FULL - 1);
      run_cmd(32767);
      run_cmd(-32768);

      // strided sweep over the whole range
      for (int v = -32768; v <= 32767; v += 257) run_cmd(v);

      // R10: two requests during a run, the last one wins
      clear_log();
      pulse_req(500);
      repeat (2) @(negedge clk);
      upd_req = 1'b1; upd_cmd = 16'sd700;
      @(negedge clk);
      upd_req = 1'b0;
      @(negedge clk);
      upd_req = 1'b1; upd_cmd = -16'sd900;
      @(negedge clk);
      upd_req = 1'b0;
      wait_done(2);
      repeat (20) @(posedge clk);
      check(n_wr == 4, "R10 held writes", n_wr, 4);
      check(done_cnt == 2, "R10 held sequences", done_cnt, 2);
      if (n_wr == 4) begin
         check_pair(0, 500);
         check_pair(2, -900);
      end

      // R10: request in the done cycle
      clear_log();
      pulse_req(-20000);
      for (int i = 0; i < 80 && !done; i++) @(negedge clk);
      upd_req = 1'b1; upd_cmd = 16'sd1234;
      @(negedge clk);
      upd_req = 1'b0;
      wait_done(2);
      repeat (20) @(posedge clk);
      check(n_wr == 4, "R10 done-cycle writes", n_wr, 4);
      check(done_cnt == 2, "R10 done-cycle sequences", done_cnt, 2);
      if (n_wr == 4) begin
         check_pair(0, -20000);
         check_pair(2, 1234);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule